// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit serves the memory-reference instructions of a 32-bit load-store processor with 32 general registers. It receives an already decoded instruction: the opcode, the destination/source register index, the base register index, a two's complement constant field, the value read for the base register, the value read for the source register and the incremented program counter. From the opcode it chooses one of three address bases: no base (direct), the base register, or the program counter. It adds the sign-extended constant to that base. It then either issues a word read, issues a word write, or returns the computed address itself for the register file.

Memory is reached through a single word port. The port uses a request strobe, a write enable and a ready input. The address is always word aligned. Byte order on the data bus is big-endian. Results go back to the register write port as a one-cycle completion pulse. That pulse carries a write enable, the register index and the data.

The controller has four states. ST_IDLE accepts an instruction. ST_READ holds a read request until ready. ST_WRITE holds a write request until ready. ST_RESP drives the one-cycle completion pulse. The transitions are:
- ST_IDLE to ST_READ on an accepted ld or ldr.
- ST_IDLE to ST_WRITE on an accepted st.
- ST_IDLE to ST_RESP on an accepted la or lar.
- ST_READ or ST_WRITE to ST_RESP when ready is high.
- ST_RESP to ST_IDLE always.
- Any other opcode leaves the unit in ST_IDLE.

Top module: `lsu_ea_unit`

## Requirements
- R1: After reset the unit is in ST_IDLE. In that state `issue_ready` is 1, and `mem_req` and `done` are 0.
- R2: Opcode 1 (load) with a nonzero base index reads memory at `cst` (sign-extended) plus `rb_val`. The returned word is written to register `ra_idx`.
- R3: For opcodes 1, 3 and 5, a base index of 0 selects direct mode. The base is then zero, whatever the value of `rb_val`.
- R4: Opcode 3 (store) writes `ra_val` to the computed address. Its completion pulse has `wr_en` at 0.
- R5: Opcode 5 (load address) writes the full computed address to register `ra_idx`. It makes no memory request, and `done` rises in the cycle after issue.
- R6: Opcode 2 (relative load) reads memory at `pc_next` plus the sign-extended constant. The base index is ignored.
- R7: Opcode 6 (relative address) writes `pc_next` plus the sign-extended constant to `ra_idx`. It makes no memory request.
- R8: The constant field is CONST_W bits wide, with bit CONST_W-1 as the sign. Every addition wraps modulo 2^32.
- R9: `mem_addr[1:0]` is always 00 during a request. The address written back by opcodes 5 and 6 keeps all 32 bits.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_we`, `mem_addr` and `mem_wdata` hold their values. `done` is high for exactly the one cycle after the ready cycle.
- R11: Bits 31..24 of the data bus belong to the byte at the lowest address of the word. Bits 7..0 belong to the byte at the highest address.
- R12: An opcode other than 1, 2, 3, 5 or 6 is ignored: no request is made, no `done` is produced, and `issue_ready` stays 1.
- R13: An instruction is accepted only while `issue_ready` is 1. An `issue_valid` seen while an access is outstanding is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction fields are valid |
| issue_ready | output | 1 | Unit is idle and can accept an instruction |
| op | input | 5 | Decoded opcode |
| ra_idx | input | 5 | Destination or store-source register index |
| rb_idx | input | 5 | Base register index (0 means no base) |
| cst | input | 17 | Two's complement constant field |
| rb_val | input | 32 | Value of the base register |
| ra_val | input | 32 | Value of the store-source register |
| pc_next | input | 32 | Address of the following instruction |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Store data, big-endian lanes |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 32 | Load data, big-endian lanes, valid with ready |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Register write enable, valid with done |
| wr_idx | output | 5 | Register written, valid with done |
| wr_data | output | 32 | Data written, valid with done |

## Verification
Every opcode value is swept against both a zero and a nonzero base index. The constants used include zero, the largest positive value, the most negative value, -1 and small negatives. Together these expose the following faults:
- A unit that adds R[0] in direct mode returns an address offset by the base value.
- A unit that zero-extends the constant lands far above the intended address.
- A unit that carries out of bit 31 loses the wrap.

Memory ready is delayed by zero to three cycles, and the instruction inputs are scrambled after issue. A unit that samples its inputs late, or lets the request drift before ready, is caught. The same happens when a unit accepts a second issue while busy, since that produces an extra completion. The bench memory stores bytes and assembles words big-endian, so a swapped lane order returns wrong load data. Illegal opcodes are checked for any request or completion pulse.

// File: rtl/lsea_pkg.sv
package lsea_pkg;

    localparam int OPC_W = 5;

    localparam logic [OPC_W-1:0] OPC_LD  = 5'd1;
    localparam logic [OPC_W-1:0] OPC_LDR = 5'd2;
    localparam logic [OPC_W-1:0] OPC_ST  = 5'd3;
    localparam logic [OPC_W-1:0] OPC_LA  = 5'd5;
    localparam logic [OPC_W-1:0] OPC_LAR = 5'd6;

    typedef enum logic [1:0] {
        BASE_ZERO,
        BASE_REG,
        BASE_PC
    } base_sel_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE,
        ACC_ADDR
    } acc_kind_e;

    typedef struct packed {
        base_sel_e base;
        acc_kind_e acc;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_RESP
    } state_e;

endpackage

// File: rtl/lsea_decode.sv
module lsea_decode
    import lsea_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [OPC_W-1:0]  op,
    input  logic [REG_AW-1:0] rb_idx,
    output mode_t             mode
);

    logic rb_is_zero;

    assign rb_is_zero = (rb_idx == '0);

    always_comb begin
        mode.base = BASE_ZERO;
        mode.acc  = ACC_NONE;
        unique case (op)
            OPC_LD: begin
                mode.base = rb_is_zero ? BASE_ZERO : BASE_REG;
                mode.acc  = ACC_READ;
            end
            OPC_ST: begin
                mode.base = rb_is_zero ? BASE_ZERO : BASE_REG;
                mode.acc  = ACC_WRITE;
            end
            OPC_LA: begin
                mode.base = rb_is_zero ? BASE_ZERO : BASE_REG;
                mode.acc  = ACC_ADDR;
            end
            OPC_LDR: begin
                mode.base = BASE_PC;
                mode.acc  = ACC_READ;
            end
            OPC_LAR: begin
                mode.base = BASE_PC;
                mode.acc  = ACC_ADDR;
            end
            default: begin
                mode.base = BASE_ZERO;
                mode.acc  = ACC_NONE;
            end
        endcase
    end

endmodule

// File: rtl/lsea_agen.sv
module lsea_agen
    import lsea_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CONST_W = 17
) (
    input  base_sel_e         base_sel,
    input  logic [CONST_W-1:0] cst,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [XLEN-1:0]   pc_next,
    output logic [XLEN-1:0]   ea,
    output logic [XLEN-1:0]   word_addr
);

    localparam int EXT_W = XLEN - CONST_W;

    logic [XLEN-1:0] cst_ext;
    logic [XLEN-1:0] base_val;

    assign cst_ext = {{EXT_W{cst[CONST_W-1]}}, cst};

    always_comb begin
        unique case (base_sel)
            BASE_REG: base_val = rb_val;
            BASE_PC:  base_val = pc_next;
            default:  base_val = '0;
        endcase
    end

    // modulo 2^XLEN addition: carry out is dropped
    assign ea        = base_val + cst_ext;
    assign word_addr = {ea[XLEN-1:2], 2'b00};

endmodule

// File: rtl/lsea_ctrl.sv
module lsea_ctrl
    import lsea_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  acc_kind_e         acc,
    input  logic [REG_AW-1:0] ra_idx,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   ea,
    input  logic [XLEN-1:0]   word_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_ready,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              done,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_idx,
    output logic [XLEN-1:0]   wr_data
);

    state_e            state_q, state_d;
    logic              accept;
    logic [XLEN-1:0]   addr_q;
    logic [XLEN-1:0]   data_q;
    logic [REG_AW-1:0] idx_q;
    logic              wen_q;

    assign accept = issue_valid && (state_q == ST_IDLE) && (acc != ACC_NONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (acc)
                        ACC_READ:  state_d = ST_READ;
                        ACC_WRITE: state_d = ST_WRITE;
                        ACC_ADDR:  state_d = ST_RESP;
                        default:   state_d = ST_IDLE;
                    endcase
                end
            end
            ST_READ:  if (mem_ready) state_d = ST_RESP;
            ST_WRITE: if (mem_ready) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            idx_q  <= '0;
            wen_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= word_addr;
                idx_q  <= ra_idx;
                wen_q  <= (acc != ACC_WRITE);
                data_q <= (acc == ACC_WRITE) ? ra_val : ea;
            end else if (state_q == ST_READ && mem_ready) begin
                data_q <= mem_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        issue_ready = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = addr_q;
        mem_wdata   = '0;
        done        = 1'b0;
        wr_en       = 1'b0;
        wr_idx      = idx_q;
        wr_data     = data_q;
        unique case (state_q)
            ST_IDLE:  issue_ready = 1'b1;
            ST_READ:  mem_req = 1'b1;
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = data_q;
            end
            ST_RESP: begin
                done  = 1'b1;
                wr_en = wen_q;
            end
        endcase
    end

    // R10: request fields frozen while waiting for ready
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_we) &&
                                 $stable(mem_addr) && $stable(mem_wdata));

    // R10: completion is a single-cycle pulse after ready
    p_done_after_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready |=> done);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: read data reaches the write port
    p_read_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready |=> wr_en && wr_data == $past(mem_rdata));

    // R4: stores complete without a register write
    p_store_nowb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ready |=> done && !wr_en);

    // R5: address-only opcodes skip memory
    p_addr_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ready && issue_valid && acc == ACC_ADDR |=> done && !mem_req);

    // R12: unknown opcodes leave the unit idle
    p_illegal_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ready && issue_valid && acc == ACC_NONE |=> issue_ready && !done);

    // R13: never ready while work is outstanding
    p_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ready |-> !mem_req && !done);

endmodule

// File: rtl/lsu_ea_unit.sv
module lsu_ea_unit
    import lsea_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int REG_AW  = 5,
    parameter int CONST_W = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    output logic               issue_ready,
    input  logic [OPC_W-1:0]   op,
    input  logic [REG_AW-1:0]  ra_idx,
    input  logic [REG_AW-1:0]  rb_idx,
    input  logic [CONST_W-1:0] cst,
    input  logic [XLEN-1:0]    rb_val,
    input  logic [XLEN-1:0]    ra_val,
    input  logic [XLEN-1:0]    pc_next,
    output logic               mem_req,
    output logic               mem_we,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    mem_wdata,
    input  logic               mem_ready,
    input  logic [XLEN-1:0]    mem_rdata,
    output logic               done,
    output logic               wr_en,
    output logic [REG_AW-1:0]  wr_idx,
    output logic [XLEN-1:0]    wr_data
);

    mode_t           mode;
    logic [XLEN-1:0] ea;
    logic [XLEN-1:0] word_addr;

    lsea_decode #(.REG_AW(REG_AW)) u_decode (
        .op     (op),
        .rb_idx (rb_idx),
        .mode   (mode)
    );

    lsea_agen #(.XLEN(XLEN), .CONST_W(CONST_W)) u_agen (
        .base_sel  (mode.base),
        .cst       (cst),
        .rb_val    (rb_val),
        .pc_next   (pc_next),
        .ea        (ea),
        .word_addr (word_addr)
    );

    lsea_ctrl #(.XLEN(XLEN), .REG_AW(REG_AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_ready (issue_ready),
        .acc         (mode.acc),
        .ra_idx      (ra_idx),
        .ra_val      (ra_val),
        .ea          (ea),
        .word_addr   (word_addr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .done        (done),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data)
    );

    // R9: the memory port only sees word addresses
    p_word_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R1: no activity in the cycle reset is released
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !mem_req && !done);

endmodule

// File: tb/lsu_ea_unit_tb_top.sv
module lsu_ea_unit_tb_top;

    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int CONST_W = 17;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               issue_valid;
    logic               issue_ready;
    logic [4:0]         op;
    logic [REG_AW-1:0]  ra_idx;
    logic [REG_AW-1:0]  rb_idx;
    logic [CONST_W-1:0] cst;
    logic [XLEN-1:0]    rb_val;
    logic [XLEN-1:0]    ra_val;
    logic [XLEN-1:0]    pc_next;
    logic               mem_req;
    logic               mem_we;
    logic [XLEN-1:0]    mem_addr;
    logic [XLEN-1:0]    mem_wdata;
    logic               mem_ready;
    logic [XLEN-1:0]    mem_rdata;
    logic               done;
    logic               wr_en;
    logic [REG_AW-1:0]  wr_idx;
    logic [XLEN-1:0]    wr_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] mem_b [256];

    always #5 clk = ~clk;

    lsu_ea_unit #(.XLEN(XLEN), .REG_AW(REG_AW), .CONST_W(CONST_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .op(op), .ra_idx(ra_idx), .rb_idx(rb_idx), .cst(cst), .rb_val(rb_val),
        .ra_val(ra_val), .pc_next(pc_next), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .done(done), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // R11: big-endian word assembly, lowest byte address in bits 31..24
    function automatic logic [31:0] rd_word(input logic [31:0] a);
        logic [7:0] b;
        b = a[7:0];
        return {mem_b[b], mem_b[b + 8'd1], mem_b[b + 8'd2], mem_b[b + 8'd3]};
    endfunction

    task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
        logic [7:0] b;
        b = a[7:0];
        mem_b[b]        = d[31:24];
        mem_b[b + 8'd1] = d[23:16];
        mem_b[b + 8'd2] = d[15:8];
        mem_b[b + 8'd3] = d[7:0];
    endtask

    function automatic logic [31:0] sext(input logic [CONST_W-1:0] c);
        return {{(XLEN-CONST_W){c[CONST_W-1]}}, c};
    endfunction

    function automatic logic [CONST_W-1:0] cst_pick(input int k);
        case (k)
            0: return 17'h00000;
            1: return 17'h00004;
            2: return 17'h0FFFF;   // largest positive
            3: return 17'h10000;   // most negative
            4: return 17'h1FFFF;   // -1
            default: return 17'h1FFF6; // -10
        endcase
    endfunction

    task automatic run_one(input logic [4:0] o, input logic [4:0] ra, input logic [4:0] rb,
                           input logic [CONST_W-1:0] c, input logic [31:0] rbv,
                           input logic [31:0] rav, input logic [31:0] pcv, input int lat,
                           input bit poke_busy);
        logic [31:0] base, ea, wa, exp_rd, req_addr, req_wdata;
        bit          legal, is_rd, is_wr, is_adr, seen_req, fin;
        int          waits;
        legal  = (o == 1 || o == 2 || o == 3 || o == 5 || o == 6);
        is_rd  = (o == 1 || o == 2);
        is_wr  = (o == 3);
        is_adr = (o == 5 || o == 6);
        if (o == 2 || o == 6) base = pcv;          // R6 R7
        else if (rb == 0)     base = 32'h0;        // R3 direct mode
        else                  base = rbv;
        ea = base + sext(c);                       // R8 wraps in 32 bits
        wa = {ea[31:2], 2'b00};
        exp_rd = rd_word(wa);

        @(negedge clk);
        op = o; ra_idx = ra; rb_idx = rb; cst = c; rb_val = rbv; ra_val = rav; pc_next = pcv;
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        // scramble inputs: the unit must have latched what it needs
        rb_val = ~rbv; ra_val = ~rav; pc_next = ~pcv; cst = ~c; ra_idx = ~ra;

        if (!legal) begin
            for (int i = 0; i < 3; i++) begin
                chk(issue_ready && !mem_req && !done, "R12 illegal opcode ignored",
                    {29'd0, issue_ready, mem_req, done}, 32'h4);
                @(negedge clk);
            end
            return;
        end

        seen_req = 0; fin = 0; waits = 0;
        for (int cyc = 0; cyc < 20 && !fin; cyc++) begin
            if (mem_req) begin
                if (!seen_req) begin
                    seen_req  = 1;
                    req_addr  = mem_addr;
                    req_wdata = mem_wdata;
                    chk(mem_addr == wa, is_wr ? "R4 store address" :
                        (o == 2 ? "R6 relative load address" : "R2 load address"), mem_addr, wa);
                    chk(mem_addr[1:0] == 2'b00, "R9 word aligned request", mem_addr, wa);
                    chk(mem_we == is_wr, "R4 write enable", {31'd0, mem_we}, {31'd0, is_wr});
                    if (is_wr) chk(mem_wdata == rav, "R4 store data", mem_wdata, rav);
                    if (poke_busy) begin
                        op = 5'd5; issue_valid = 1'b1;   // R13 must be dropped
                    end
                end else begin
                    chk(mem_addr == req_addr && mem_wdata == req_wdata && mem_we == is_wr,
                        "R10 request held", mem_addr, req_addr);
                end
                if (waits >= lat) begin
                    mem_ready = 1'b1;
                    mem_rdata = rd_word(mem_addr);
                    if (mem_we) wr_word(mem_addr, mem_wdata);
                end
                waits++;
                @(negedge clk);
                mem_ready = 1'b0;
                mem_rdata = 32'hDEAD_BEEF;
            end else if (done) begin
                issue_valid = 1'b0;
                fin = 1;
                if (is_adr) begin
                    chk(!seen_req, o == 5 ? "R5 no memory access" : "R7 no memory access",
                        {31'd0, seen_req}, 32'd0);
                    chk(wr_en && wr_data == ea, o == 5 ? "R5 address written back" :
                        "R7 relative address written back", wr_data, ea);
                    chk(cyc == 0, "R5 done one cycle after issue", cyc, 0);
                end else if (is_rd) begin
                    chk(wr_en && wr_data == exp_rd, "R11 R2 big-endian load data", wr_data, exp_rd);
                    chk(waits == lat + 1, "R10 done right after ready", waits, lat + 1);
                end else begin
                    chk(!wr_en, "R4 store has no register write", {31'd0, wr_en}, 32'd0);
                    chk(seen_req, "R4 store made a request", {31'd0, seen_req}, 32'd1);
                end
                chk(wr_idx == ra, "R2 write index", {27'd0, wr_idx}, {27'd0, ra});
                @(negedge clk);
                chk(!done && issue_ready, "R13 R10 single completion", {30'd0, done, issue_ready},
                    32'h1);
            end else begin
                @(negedge clk);
            end
        end
        if (!fin) chk(0, "R10 completion missing", 0, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_b[i] = 8'(i * 7 + 3);
        rst_n = 1'b0; issue_valid = 1'b0; mem_ready = 1'b0; mem_rdata = '0;
        op = '0; ra_idx = '0; rb_idx = '0; cst = '0; rb_val = '0; ra_val = '0; pc_next = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(issue_ready && !mem_req && !done, "R1 reset state",
            {29'd0, issue_ready, mem_req, done}, 32'h4);

        // R11: single directed store then load of a known pattern
        run_one(5'd3, 5'd4, 5'd0, 17'h00040, 32'h0, 32'h1122_3344, 32'h0, 1, 0);
        chk(mem_b[8'h40] == 8'h11 && mem_b[8'h43] == 8'h44, "R11 store byte order",
            {mem_b[8'h40], mem_b[8'h43]}, 32'h1144);

        // sweep every opcode, both base kinds and the constant corners
        for (int o = 0; o < 32; o++) begin
            for (int r = 0; r < 2; r++) begin
                for (int k = 0; k < 6; k++) begin
                    int idx;
                    logic [31:0] rbv, pcv;
                    idx = o * 12 + r * 6 + k;
                    rbv = (k == 2) ? 32'hFFFF_FFF0 : 32'h0000_1000 + 32'(idx * 52);
                    pcv = (k == 3) ? 32'h0000_8004 : 32'hFFFF_FFF8 + 32'(idx * 4);
                    run_one(5'(o), 5'(idx % 31 + 1), (r == 0) ? 5'd0 : 5'd7, cst_pick(k),
                            rbv, 32'hA5A5_0000 ^ 32'(idx), pcv, idx % 4, (idx % 4) != 0);
                end
            end
        end
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        report();
    end

endmodule